// File: doc/BRIEF.md
# Sequential Four-Sample Rounded Scaler

This block takes four unsigned 8-bit samples, adds them one per clock into a cleared accumulator, divides the total by eight and rounds the result to the nearest integer. A small state machine controls the order of the register updates. An accumulate datapath selects one sample at a time from the parallel sample bus. A rounding stage registers the final value.

The host waits until `ready_o` is high. It then places the four samples on `samples_i` and pulses `start_i`. The samples must stay stable until `ready_o` returns. The rounded result stays on `result_o` until the next accepted start. Busy time is one cycle per sample plus one rounding cycle.

Top module: `quad_round_scaler`

## Requirements
- R1: While `rst_ni` is low, and immediately after it falls, even in the middle of an operation, `ready_o` is 1 and `result_o` is 0.
- R2: A start is accepted only on a clock edge where `start_i` and `ready_o` are both high. `ready_o` is low in the cycle after an accepted start.
- R3: After an accepted start, `ready_o` stays low for exactly five cycles: four accumulate cycles and one rounding cycle. It rises on the same edge that loads the new `result_o`.
- R4: The total is the sum of the four samples. Sample k occupies bits [8k+7:8k] of `samples_i`.
- R5: When the low three bits of the total are 0 to 3, `result_o` equals the total shifted right by three.
- R6: When the low three bits of the total are 4 to 7, `result_o` equals the total shifted right by three, plus one.
- R7: The accumulator never wraps. The largest total is 1020, which gives a result of 128, and `result_o` never exceeds 128.
- R8: A `start_i` pulse while `ready_o` is low is ignored. It does not change the timing of `ready_o` or the result of the running operation.
- R9: `result_o` changes only at the end of an operation. It holds its value while idle and while busy, even when the samples change.
- R10: Every accepted start clears the accumulator, so a result never depends on the samples of an earlier operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; only taken while ready |
| samples_i | input | 32 | Four unsigned samples, sample k at bits [8k+7:8k] |
| ready_o | output | 1 | High while idle and able to accept a start |
| result_o | output | 8 | Rounded total divided by eight |

## Verification
The bench aims at the rounding boundary. Totals whose low bits are exactly 3 and exactly 4 expose a comparison that is off by one: it would round 3 up or leave 4 down. All-255 samples would reach 128 only if the accumulator is wide enough; a narrow one wraps to a small value. Sample positions are tested one at a time, so an index that skips or repeats a sample shows up as a wrong total. Back-to-back operations, a stray start while busy and a reset in mid-operation would expose a stale accumulator, a restarted sequence or a five-cycle window of the wrong length.

// File: rtl/quad_scaler_pkg.sv
package quad_scaler_pkg;
  localparam int unsigned DIV_SHIFT = 3;  // divisor fixed at eight

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_RND  = 2'd2
  } state_e;
endpackage

// File: rtl/scaler_ctrl.sv
module scaler_ctrl
  import quad_scaler_pkg::*;
#(
  parameter int unsigned N_SAMPLES = 4,
  localparam int unsigned IDX_W = (N_SAMPLES > 1) ? $clog2(N_SAMPLES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             ready_o,
  output logic             clr_o,
  output logic             add_o,
  output logic             load_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SAMPLES - 1);

  state_e state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_ACC;
        idx_d   = '0;
      end
      ST_ACC: begin
        if (idx_q == LAST_IDX) state_d = ST_RND;
        else                   idx_d   = idx_q + 1'b1;
      end
      ST_RND:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign clr_o   = ready_o && start_i;
  assign add_o   = (state_q == ST_ACC);
  assign load_o  = (state_q == ST_RND);
  assign idx_o   = idx_q;

  // busy-window counter for the latency check
  logic [IDX_W+1:0] busy_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_cnt_q <= '0;
    else if (clr_o)   busy_cnt_q <= '0;
    else if (!ready_o) busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  // R2
  start_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> !ready_o);

  // R3
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (busy_cnt_q == (IDX_W+2)'(N_SAMPLES + 1)));

  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_o && start_i && idx_o != LAST_IDX) |=> add_o);
endmodule

// File: rtl/scaler_accum.sv
module scaler_accum #(
  parameter int unsigned SAMPLE_W  = 8,
  parameter int unsigned N_SAMPLES = 4,
  localparam int unsigned IDX_W = (N_SAMPLES > 1) ? $clog2(N_SAMPLES) : 1,
  localparam int unsigned ACC_W = SAMPLE_W + IDX_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_SAMPLES*SAMPLE_W-1:0] samples_i,
  input  logic                          clr_i,
  input  logic                          add_i,
  input  logic [IDX_W-1:0]              idx_i,
  output logic [ACC_W-1:0]              acc_o
);
  logic [SAMPLE_W-1:0] lane [N_SAMPLES];
  logic [SAMPLE_W-1:0] pick;

  for (genvar k = 0; k < N_SAMPLES; k++) begin : g_lane
    assign lane[k] = samples_i[k*SAMPLE_W +: SAMPLE_W];
  end

  always_comb begin
    pick = '0;
    for (int k = 0; k < N_SAMPLES; k++) begin
      if (idx_i == IDX_W'(k)) pick = lane[k];
    end
  end

  logic [ACC_W-1:0] acc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (add_i) acc_q <= acc_q + ACC_W'(pick);
  end
  assign acc_o = acc_q;

  // R10
  acc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_o == '0));

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !clr_i) |=> (acc_o >= $past(acc_o)));
endmodule

// File: rtl/scaler_round.sv
module scaler_round
  import quad_scaler_pkg::*;
#(
  parameter int unsigned ACC_W = 10,
  localparam int unsigned RES_W = ACC_W - DIV_SHIFT + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [RES_W-1:0] result_o
);
  localparam logic [DIV_SHIFT-1:0] HALF_M1 = DIV_SHIFT'((1 << (DIV_SHIFT - 1)) - 1);
  localparam logic [RES_W-1:0]     RES_MAX = RES_W'(1) << (RES_W - 1);

  logic [ACC_W-DIV_SHIFT-1:0] quot;
  logic [DIV_SHIFT-1:0]       rem;
  logic                       up;
  logic [RES_W-1:0]           rounded;

  assign quot    = acc_i[ACC_W-1:DIV_SHIFT];
  assign rem     = acc_i[DIV_SHIFT-1:0];
  assign up      = (rem > HALF_M1);
  assign rounded = {1'b0, quot} + RES_W'(up);

  logic [RES_W-1:0] res_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (load_i) res_q <= rounded;
  end
  assign result_o = res_q;

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(result_o));

  // R7
  result_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o <= RES_MAX);
endmodule

// File: rtl/quad_round_scaler.sv
module quad_round_scaler
  import quad_scaler_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 8,
  parameter int unsigned N_SAMPLES = 4,
  localparam int unsigned IDX_W = (N_SAMPLES > 1) ? $clog2(N_SAMPLES) : 1,
  localparam int unsigned ACC_W = SAMPLE_W + IDX_W,
  localparam int unsigned RES_W = ACC_W - DIV_SHIFT + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [N_SAMPLES*SAMPLE_W-1:0] samples_i,
  output logic                          ready_o,
  output logic [RES_W-1:0]              result_o
);
  logic             clr, add, load;
  logic [IDX_W-1:0] idx;
  logic [ACC_W-1:0] acc;

  scaler_ctrl #(.N_SAMPLES(N_SAMPLES)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .ready_o (ready_o),
    .clr_o   (clr),
    .add_o   (add),
    .load_o  (load),
    .idx_o   (idx)
  );

  scaler_accum #(.SAMPLE_W(SAMPLE_W), .N_SAMPLES(N_SAMPLES)) i_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .samples_i (samples_i),
    .clr_i     (clr),
    .add_i     (add),
    .idx_i     (idx),
    .acc_o     (acc)
  );

  scaler_round #(.ACC_W(ACC_W)) i_round (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .acc_i    (acc),
    .result_o (result_o)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (ready_o && result_o == '0));
endmodule

// File: tb/test_quad_round_scaler.sv
module test_quad_round_scaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] samples = '0;
  logic        ready;
  logic [7:0]  result;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  quad_round_scaler i_quad_round_scaler (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .samples_i (samples),
    .ready_o   (ready),
    .result_o  (result)
  );

  function automatic int ref_round(int a, int b, int c, int d);
    int s = a + b + c + d;
    return s / 8 + (((s % 8) > 3) ? 1 : 0);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, updated on each rising edge
  int m_busy = 0;
  int m_res = 0;
  int m_pend = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0;
      m_res  = 0;
    end else if (m_busy == 0 && start) begin
      m_busy = 5;
      m_pend = ref_round(samples[7:0], samples[15:8], samples[23:16], samples[31:24]);
    end else if (m_busy > 0) begin
      m_busy--;
      if (m_busy == 0) m_res = m_pend;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 ready vs model", int'(ready), (m_busy == 0) ? 1 : 0);
      chk("R9 result vs model", int'(result), m_res);
    end
  end

  task automatic run_op(string tag, int a, int b, int c, int d);
    int low = 1;
    samples = {d[7:0], c[7:0], b[7:0], a[7:0]};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 ready low after start", int'(ready), 0);
    while (!ready) begin
      @(negedge clk);
      if (!ready) low++;
    end
    chk("R3 busy cycles", low, 5);
    chk(tag, int'(result), ref_round(a, b, c, d));
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #20;
    chk("R1 ready in reset", int'(ready), 1);
    chk("R1 result in reset", int'(result), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(ready), 1);

    run_op("R6 total 100 rounds up", 10, 20, 30, 40);
    chk("R6 value", int'(result), 13);
    run_op("R5 total 99 truncates", 0, 0, 0, 99);
    chk("R5 value", int'(result), 12);
    run_op("R4 lane 0", 64, 0, 0, 0);
    chk("R4 lane 0 value", int'(result), 8);
    run_op("R4 lane 1", 0, 72, 0, 0);
    run_op("R4 lane 2", 0, 0, 80, 0);
    run_op("R4 lane 3", 0, 0, 0, 88);
    chk("R4 lane 3 value", int'(result), 11);
    run_op("R7 max total", 255, 255, 255, 255);
    chk("R7 value 128", int'(result), 128);
    run_op("R10 zeros after max", 0, 0, 0, 0);
    chk("R10 value 0", int'(result), 0);
    run_op("R6 remainder 4", 1, 1, 1, 1);
    chk("R6 remainder 4 value", int'(result), 1);
    run_op("R5 remainder 3", 1, 1, 1, 0);
    chk("R5 remainder 3 value", int'(result), 0);

    // R8: stray start while busy
    samples = {8'd50, 8'd40, 8'd30, 8'd21};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 still busy", int'(ready), 0);
    @(negedge clk);
    chk("R8 ready on time", int'(ready), 1);
    chk("R8 result", int'(result), ref_round(21, 30, 40, 50));
    @(negedge clk);
    chk("R8 no restart", int'(ready), 1);

    // R9: held while idle with changing samples
    for (int i = 0; i < 6; i++) begin
      samples = 32'h1234_5678 * (i + 1);
      @(negedge clk);
      chk("R9 held while idle", int'(result), ref_round(21, 30, 40, 50));
    end

    // R1: reset during an operation
    run_op("R10 before reset", 200, 100, 50, 25);
    samples = {8'd9, 8'd9, 8'd9, 8'd9};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 ready mid-op reset", int'(ready), 1);
    chk("R1 result mid-op reset", int'(result), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_op("R10 after reset", 3, 4, 5, 6);

    for (int i = 0; i < 40; i++) begin
      int a = (i * 37 + 11) % 256;
      int b = (i * 91 + 5) % 256;
      int c = (i * 53 + 200) % 256;
      int d = (i * 17 + 99) % 256;
      run_op("R4 mixed totals", a, b, c, d);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule